// File: doc/BRIEF.md
# Power-up Sequencer and Fault Supervisor for a Flyback Controller

This block decides when a switching converter may switch, and decides when it must stop. After power-on reset the supply capacitor charges through the start-up current source. Once the supply comparator reports the turn-on level (about 18 V), the source is switched off and switching is enabled. The peak-current limit then rises in timed steps from 0.32 V to 1.0 V. While switching is enabled, the block watches the comparator flags for supply overvoltage, supply undervoltage, overtemperature, feedback overload, output overvoltage and shorted winding. Each flag is qualified by its own blanking window and, where it matters, by whether the power switch is on or off.

Faults fall into two classes. A self-recovering fault stops switching and waits until the supply has drained below the off level (about 10.5 V). The supply is then recharged, and switching resumes at the lowest soft-start step. A latched fault also stops switching, and switching never resumes. The start-up source keeps cycling the supply between the off and on levels until an external power-on reset clears the block. All thresholds arrive as digital comparator flags, and all times are given in clock cycles.

Top module: `pwr_supervisor`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `run_en` is 0, `startup_en` is 1, `ss_level` is 0, `restart_wait` is 0, `latched` is 0 and `fault_code` is 0.
- R2: While waiting to start, a clock edge that samples `vcc_above_on` high sets `run_en` and clears `startup_en` at that same edge. `run_en` and `startup_en` are never both high.
- R3: While running, `ss_level` equals min(SS_STEPS, k / SS_STEP_CYC), where k is the number of clock edges spent in the run state since the edge that entered it. `ss_limit_mv` equals 320 + 170 × `ss_level`. When `run_en` is 0, `ss_level` is 0.
- R4: While running, `vcc_over` or `temp_hot` stops switching at the next edge without blanking. `vcc_below_off` does the same. Each of these is a self-recovering fault.
- R5: While running, `fb_overload` stops switching as a self-recovering fault only when it has been high for OLP_BLANK_CYC consecutive clock edges. A shorter burst has no effect.
- R6: After a self-recovering fault, `restart_wait` is 1 and `startup_en` stays 0 until `vcc_below_off` is sampled. `startup_en` then rises, and the block waits for `vcc_above_on`. Switching then restarts with `ss_level` 0 and `fault_code` 0.
- R7: While running with `gate_on` low, `zc_ovp` held for ZC_BLANK_CYC consecutive edges latches the block. While `gate_on` is high, `zc_ovp` is ignored.
- R8: While running with `gate_on` high, `cs_short` held for CS_BLANK_CYC consecutive edges latches the block. While `gate_on` is low, `cs_short` is ignored.
- R9: While latched, `run_en` stays 0 whatever the inputs do. `startup_en` rises at an edge that samples `vcc_below_off` and falls at an edge that samples `vcc_above_on`, and this repeats indefinitely.
- R10: When a latching condition and a self-recovering condition qualify on the same edge, the block latches.
- R11: Only `rst` leaves the latched state.
- R12: `fault_code` holds the last trip cause: 0 none, 1 supply overvoltage, 2 supply undervoltage, 3 overtemperature, 4 overload, 5 output overvoltage, 6 shorted winding. On simultaneous self-recovering causes the priority is 1, then 3, then 4, then 2. A shorted winding outranks an output overvoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| vcc_above_on | input | 1 | Supply above turn-on level |
| vcc_below_off | input | 1 | Supply below turn-off level |
| vcc_over | input | 1 | Supply above overvoltage level |
| temp_hot | input | 1 | Junction overtemperature |
| fb_overload | input | 1 | Feedback above overload level |
| zc_ovp | input | 1 | Zero-crossing voltage above output overvoltage level |
| cs_short | input | 1 | Current sense above shorted-winding level |
| gate_on | input | 1 | Power switch currently on |
| run_en | output | 1 | Switching permitted |
| startup_en | output | 1 | Start-up current source enable |
| ss_level | output | $clog2(SS_STEPS+1) | Soft-start step index |
| ss_limit_mv | output | 16 | Current-sense limit for the step, in mV |
| restart_wait | output | 1 | Waiting out a self-recovering fault |
| latched | output | 1 | Latched fault, switching disabled until reset |
| fault_code | output | 3 | Last trip cause |

## Verification
The hardest case to reach is one where a latching and a self-recovering cause qualify on exactly the same edge. The shorted-winding flag must first be held with the switch on for one edge fewer than its blanking window. Overtemperature is then raised for the single edge on which the blanking completes. The bench also holds each blanked flag for one edge fewer than its window and then releases it, and it drives each gated flag in the opposite switch phase, to show that neither case leads to a trip. A behavioural model tracks the run length of every flag and compares all outputs on every cycle.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

    typedef enum logic [1:0] {
        ST_CHARGE  = 2'd0,
        ST_RUN     = 2'd1,
        ST_RESTART = 2'd2,
        ST_LATCH   = 2'd3
    } sup_state_e;

    typedef enum logic [2:0] {
        FC_NONE       = 3'd0,
        FC_VCC_OV     = 3'd1,
        FC_VCC_UV     = 3'd2,
        FC_OTP        = 3'd3,
        FC_OVERLOAD   = 3'd4,
        FC_OUT_OVP    = 3'd5,
        FC_SHORT_WIND = 3'd6
    } fault_code_e;

    typedef struct packed {
        logic short_wind;
        logic out_ovp;
        logic vcc_ov;
        logic otp;
        logic overload;
        logic vcc_uv;
    } fault_vec_t;

    localparam int unsigned SS_BASE_MV = 320;
    localparam int unsigned SS_STEP_MV = 170;

    function automatic logic [15:0] ss_limit_of(input int unsigned idx);
        return 16'(SS_BASE_MV + SS_STEP_MV * idx);
    endfunction

    function automatic logic is_latching(input fault_vec_t f);
        return f.short_wind | f.out_ovp;
    endfunction

    function automatic logic is_recovering(input fault_vec_t f);
        return f.vcc_ov | f.otp | f.overload | f.vcc_uv;
    endfunction

    function automatic fault_code_e pick_fault(input fault_vec_t f);
        if (f.short_wind)    return FC_SHORT_WIND;
        else if (f.out_ovp)  return FC_OUT_OVP;
        else if (f.vcc_ov)   return FC_VCC_OV;
        else if (f.otp)      return FC_OTP;
        else if (f.overload) return FC_OVERLOAD;
        else if (f.vcc_uv)   return FC_VCC_UV;
        else                 return FC_NONE;
    endfunction

endpackage

// File: rtl/sup_hysteresis.sv
module sup_hysteresis (
    input  logic clk,
    input  logic rst,
    input  logic below_off,
    input  logic above_on,
    output logic charge_en
);
    logic chg_q;

    always_ff @(posedge clk) begin
        if (rst)            chg_q <= 1'b1;
        else if (below_off) chg_q <= 1'b1;
        else if (above_on)  chg_q <= 1'b0;
    end

    assign charge_en = chg_q;
endmodule

// File: rtl/sup_blank_filter.sv
module sup_blank_filter #(
    parameter int unsigned BLANK_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic cond,
    output logic qual
);
    localparam int unsigned CW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(BLANK_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable || !cond) cnt_q <= '0;
        else if (cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
    end

    assign qual = enable && cond && (cnt_q == CNT_MAX);
endmodule

// File: rtl/sup_softstart.sv
module sup_softstart #(
    parameter int unsigned SS_STEPS    = 4,
    parameter int unsigned SS_STEP_CYC = 375000
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             clr,
    input  logic                             cnt_en,
    output logic [$clog2(SS_STEPS+1)-1:0]    idx
);
    localparam int unsigned IDX_W = $clog2(SS_STEPS + 1);
    localparam int unsigned TW    = (SS_STEP_CYC > 1) ? $clog2(SS_STEP_CYC) : 1;
    localparam logic [TW-1:0]    T_MAX   = TW'(SS_STEP_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(SS_STEPS);

    logic [TW-1:0]    tick_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tick_q <= '0;
            idx_q  <= '0;
        end else if (cnt_en) begin
            if (tick_q == T_MAX) begin
                tick_q <= '0;
                if (idx_q != IDX_TOP) idx_q <= idx_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign idx = idx_q;
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int unsigned SS_STEPS      = 4,
    parameter int unsigned SS_STEP_CYC   = 375000,
    parameter int unsigned OLP_BLANK_CYC = 3000000,
    parameter int unsigned ZC_BLANK_CYC  = 125,
    parameter int unsigned CS_BLANK_CYC  = 24
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            vcc_above_on,
    input  logic                            vcc_below_off,
    input  logic                            vcc_over,
    input  logic                            temp_hot,
    input  logic                            fb_overload,
    input  logic                            zc_ovp,
    input  logic                            cs_short,
    input  logic                            gate_on,
    output logic                            run_en,
    output logic                            startup_en,
    output logic [$clog2(SS_STEPS+1)-1:0]   ss_level,
    output logic [15:0]                     ss_limit_mv,
    output logic                            restart_wait,
    output logic                            latched,
    output logic [2:0]                      fault_code
);
    localparam int unsigned N_FILT = 3;

    sup_state_e  state_q, state_d;
    fault_code_e code_q, code_d;
    logic        charge_en;
    logic        in_run;
    logic [N_FILT-1:0] filt_cond, filt_qual;
    fault_vec_t  fv;

    assign in_run = (state_q == ST_RUN);

    sup_hysteresis u_hyst (
        .clk       (clk),
        .rst       (rst),
        .below_off (vcc_below_off),
        .above_on  (vcc_above_on),
        .charge_en (charge_en)
    );

    // 0: overload, 1: output overvoltage (off-phase), 2: shorted winding (on-phase)
    assign filt_cond[0] = fb_overload;
    assign filt_cond[1] = zc_ovp & ~gate_on;
    assign filt_cond[2] = cs_short & gate_on;

    for (genvar g = 0; g < N_FILT; g++) begin : g_filt
        localparam int unsigned BL = (g == 0) ? OLP_BLANK_CYC :
                                     (g == 1) ? ZC_BLANK_CYC  : CS_BLANK_CYC;
        sup_blank_filter #(.BLANK_CYC(BL)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .enable (in_run),
            .cond   (filt_cond[g]),
            .qual   (filt_qual[g])
        );
    end

    always_comb begin
        fv            = '0;
        fv.overload   = filt_qual[0];
        fv.out_ovp    = filt_qual[1];
        fv.short_wind = filt_qual[2];
        fv.vcc_ov     = vcc_over;
        fv.otp        = temp_hot;
        fv.vcc_uv     = vcc_below_off;
    end

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_CHARGE: begin
                if (vcc_above_on) begin
                    state_d = ST_RUN;
                    code_d  = FC_NONE;
                end
            end
            ST_RUN: begin
                if (is_latching(fv)) begin
                    state_d = ST_LATCH;
                    code_d  = pick_fault(fv);
                end else if (is_recovering(fv)) begin
                    state_d = ST_RESTART;
                    code_d  = pick_fault(fv);
                end
            end
            ST_RESTART: begin
                if (charge_en) state_d = ST_CHARGE;
            end
            ST_LATCH: state_d = ST_LATCH;
            default:  state_d = ST_CHARGE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CHARGE;
            code_q  <= FC_NONE;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    sup_softstart #(
        .SS_STEPS    (SS_STEPS),
        .SS_STEP_CYC (SS_STEP_CYC)
    ) u_ss (
        .clk    (clk),
        .rst    (rst),
        .clr    (state_d != ST_RUN),
        .cnt_en (in_run),
        .idx    (ss_level)
    );

    assign ss_limit_mv  = ss_limit_of(32'(ss_level));
    assign run_en       = in_run;
    assign startup_en   = charge_en;
    assign restart_wait = (state_q == ST_RESTART);
    assign latched      = (state_q == ST_LATCH);
    assign fault_code   = code_q;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
    parameter int unsigned SS_STEPS = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          vcc_above_on,
    input logic                          gate_on,
    input logic                          run_en,
    input logic                          startup_en,
    input logic [$clog2(SS_STEPS+1)-1:0] ss_level,
    input logic                          latched,
    input logic [2:0]                    fault_code
);
    // R2
    run_needs_on_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |-> $past(vcc_above_on));
    // R2
    no_run_while_charging_chk: assert property (@(posedge clk) disable iff (rst)
        run_en |-> !startup_en);
    // R3
    ss_zero_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> ss_level == '0);
    // R3
    ss_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_en && !$stable(ss_level)) |-> (32'(ss_level) == 32'($past(ss_level)) + 1));
    // R7
    ovp_in_off_phase_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(latched) && fault_code == 3'd5) |-> !$past(gate_on));
    // R8
    short_in_on_phase_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(latched) && fault_code == 3'd6) |-> $past(gate_on));
    // R9
    latch_blocks_run_chk: assert property (@(posedge clk) disable iff (rst)
        latched |-> !run_en);
    // R11
    latch_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        latched |=> latched);
endmodule

bind pwr_supervisor pwr_supervisor_chk #(.SS_STEPS(SS_STEPS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .vcc_above_on (vcc_above_on),
    .gate_on      (gate_on),
    .run_en       (run_en),
    .startup_en   (startup_en),
    .ss_level     (ss_level),
    .latched      (latched),
    .fault_code   (fault_code)
);

// File: tb/pwr_supervisor_tb.sv
module pwr_supervisor_tb;
    localparam int STEPS = 4;
    localparam int STEP  = 20;
    localparam int OLP   = 30;
    localparam int ZCB   = 8;
    localparam int CSB   = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_above_on = 0, vcc_below_off = 0, vcc_over = 0, temp_hot = 0;
    logic fb_overload = 0, zc_ovp = 0, cs_short = 0, gate_on = 0;
    logic run_en, startup_en, restart_wait, latched;
    logic [2:0]  ss_level;
    logic [15:0] ss_limit_mv;
    logic [2:0]  fault_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pwr_supervisor #(
        .SS_STEPS(STEPS), .SS_STEP_CYC(STEP), .OLP_BLANK_CYC(OLP),
        .ZC_BLANK_CYC(ZCB), .CS_BLANK_CYC(CSB)
    ) u_dut (
        .clk(clk), .rst(rst), .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
        .vcc_over(vcc_over), .temp_hot(temp_hot), .fb_overload(fb_overload),
        .zc_ovp(zc_ovp), .cs_short(cs_short), .gate_on(gate_on), .run_en(run_en),
        .startup_en(startup_en), .ss_level(ss_level), .ss_limit_mv(ss_limit_mv),
        .restart_wait(restart_wait), .latched(latched), .fault_code(fault_code)
    );

    // Behavioural reference: 0 waiting to start, 1 running, 2 fault wait, 3 latched
    int m_st = 0, m_code = 0, m_chg = 1, m_k = 0;
    int m_olp = 0, m_zc = 0, m_cs = 0;
    int m_ss = 0;
    bit started = 0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_st = 0; m_code = 0; m_chg = 1; m_k = 0;
            m_olp = 0; m_zc = 0; m_cs = 0; m_ss = 0;
        end else begin
            int  ns, nc;
            bit  run, olq, zq, cq;
            ns  = m_st; nc = m_code;
            run = (m_st == 1);
            olq = run && fb_overload && (m_olp >= OLP - 1);
            zq  = run && zc_ovp && !gate_on && (m_zc >= ZCB - 1);
            cq  = run && cs_short && gate_on && (m_cs >= CSB - 1);
            case (m_st)
                0: if (vcc_above_on) begin ns = 1; nc = 0; end
                1: begin
                    if (cq)                 begin ns = 3; nc = 6; end
                    else if (zq)            begin ns = 3; nc = 5; end
                    else if (vcc_over)      begin ns = 2; nc = 1; end
                    else if (temp_hot)      begin ns = 2; nc = 3; end
                    else if (olq)           begin ns = 2; nc = 4; end
                    else if (vcc_below_off) begin ns = 2; nc = 2; end
                end
                2: if (m_chg == 1) ns = 0;
                default: ;
            endcase
            m_olp = (run && fb_overload) ? m_olp + 1 : 0;
            m_zc  = (run && zc_ovp && !gate_on) ? m_zc + 1 : 0;
            m_cs  = (run && cs_short && gate_on) ? m_cs + 1 : 0;
            if (vcc_below_off)     m_chg = 1;
            else if (vcc_above_on) m_chg = 0;
            m_k  = (ns == 1 && m_st == 1) ? m_k + 1 : 0;
            m_st = ns; m_code = nc;
            m_ss = (m_st == 1) ? ((m_k / STEP > STEPS) ? STEPS : m_k / STEP) : 0;
        end
    end

    task automatic cmp(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            cmp("R2",  "run_en",       int'(run_en),       int'(m_st == 1));
            cmp("R9",  "startup_en",   int'(startup_en),   m_chg);
            cmp("R3",  "ss_level",     int'(ss_level),     m_ss);
            cmp("R3",  "ss_limit_mv",  int'(ss_limit_mv),  320 + 170 * m_ss);
            cmp("R6",  "restart_wait", int'(restart_wait), int'(m_st == 2));
            cmp("R11", "latched",      int'(latched),      int'(m_st == 3));
            cmp("R12", "fault_code",   int'(fault_code),   m_code);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<=20000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic at_neg;
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_on;
        vcc_above_on = 1; tick(1); vcc_above_on = 0;
    endtask

    task automatic pulse_off;
        vcc_below_off = 1; tick(1); vcc_below_off = 0;
    endtask

    task automatic do_reset;
        rst = 1; tick(3); rst = 0;
    endtask

    task automatic recover;
        pulse_off; tick(2); pulse_on;
    endtask

    initial begin
        tick(3);
        at_neg;
        cmp("R1", "startup_en in reset", int'(startup_en), 1);
        tick(0);
        rst = 0;
        at_neg;
        cmp("R1", "run_en after reset", int'(run_en), 0);
        cmp("R1", "fault_code after reset", int'(fault_code), 0);
        tick(5);
        pulse_on;
        at_neg;
        cmp("R2", "run_en after turn-on", int'(run_en), 1);
        cmp("R2", "startup_en after turn-on", int'(startup_en), 0);
        tick(20);
        cmp("R3", "limit after one step", int'(ss_limit_mv), 490);
        tick(80);
        cmp("R3", "final level", int'(ss_level), 4);
        cmp("R3", "final limit", int'(ss_limit_mv), 1000);

        // R5 short burst then full window
        fb_overload = 1; tick(OLP - 1); fb_overload = 0;
        at_neg;
        cmp("R5", "run after short overload", int'(run_en), 1);
        tick(3);
        fb_overload = 1; tick(OLP); fb_overload = 0;
        at_neg;
        cmp("R5", "overload code", int'(fault_code), 4);
        cmp("R6", "restart_wait", int'(restart_wait), 1);
        tick(10);
        cmp("R6", "no charge before drain", int'(startup_en), 0);
        pulse_off;
        at_neg;
        cmp("R6", "charge after drain", int'(startup_en), 1);
        tick(3);
        pulse_on;
        at_neg;
        cmp("R6", "restart ss level", int'(ss_level), 0);
        cmp("R6", "restart code cleared", int'(fault_code), 0);
        tick(30);

        // R4 immediate faults
        temp_hot = 1; tick(1); temp_hot = 0;
        at_neg;
        cmp("R4", "otp code", int'(fault_code), 3);
        tick(2); recover; tick(5);
        vcc_over = 1; tick(1); vcc_over = 0;
        at_neg;
        cmp("R4", "vcc ov code", int'(fault_code), 1);
        tick(2); recover; tick(5);
        pulse_off;
        at_neg;
        cmp("R4", "uv code", int'(fault_code), 2);
        tick(3); pulse_on; tick(5);
        // R12 simultaneous self-recovering causes
        vcc_over = 1; temp_hot = 1; fb_overload = 1; tick(1);
        vcc_over = 0; temp_hot = 0; fb_overload = 0;
        at_neg;
        cmp("R12", "priority ov over otp", int'(fault_code), 1);
        tick(2); recover; tick(5);

        // R7 output overvoltage only in off-phase
        gate_on = 1; zc_ovp = 1; tick(30); zc_ovp = 0; gate_on = 0;
        at_neg;
        cmp("R7", "zc ignored in on-phase", int'(run_en), 1);
        zc_ovp = 1; tick(ZCB - 1); zc_ovp = 0;
        at_neg;
        cmp("R7", "zc short burst", int'(run_en), 1);
        tick(2);
        zc_ovp = 1; tick(ZCB); zc_ovp = 0;
        at_neg;
        cmp("R7", "zc latch code", int'(fault_code), 5);
        cmp("R9", "latched", int'(latched), 1);

        // R9 supply cycling while latched, R11 stays latched
        for (int i = 0; i < 3; i++) begin
            tick(4);
            pulse_off;
            at_neg;
            cmp("R9", "latched charge on", int'(startup_en), 1);
            tick(4);
            pulse_on;
            at_neg;
            cmp("R9", "latched charge off", int'(startup_en), 0);
            cmp("R9", "latched no run", int'(run_en), 0);
        end
        vcc_over = 1; temp_hot = 1; tick(5); vcc_over = 0; temp_hot = 0;
        at_neg;
        cmp("R11", "still latched", int'(latched), 1);

        // R8 shorted winding only in on-phase
        do_reset; tick(3); pulse_on; tick(5);
        cs_short = 1; tick(40); cs_short = 0;
        at_neg;
        cmp("R8", "cs ignored in off-phase", int'(run_en), 1);
        gate_on = 1; cs_short = 1; tick(CSB - 1); cs_short = 0;
        at_neg;
        cmp("R8", "cs short burst", int'(run_en), 1);
        tick(2);
        cs_short = 1; tick(CSB); cs_short = 0; gate_on = 0;
        at_neg;
        cmp("R8", "short latch code", int'(fault_code), 6);

        // R10 latch wins over a simultaneous self-recovering cause
        do_reset; tick(3); pulse_on; tick(5);
        gate_on = 1; cs_short = 1; tick(CSB - 1);
        temp_hot = 1; tick(1);
        temp_hot = 0; cs_short = 0; gate_on = 0;
        at_neg;
        cmp("R10", "latch priority", int'(latched), 1);
        cmp("R10", "latch priority code", int'(fault_code), 6);
        tick(5);
        do_reset;
        at_neg;
        cmp("R11", "reset clears latch", int'(latched), 0);
        tick(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule